// File: doc/BRIEF.md
# Hardware Cursor Overlay Unit

This block lays a 32-pixel-wide, two-plane pointer image over an 8-bit indexed pixel stream. For every clock it takes the beam coordinates and the screen pixel, decides whether the beam lies inside the pointer window, and returns either the screen pixel or a pointer-modified value one cycle later. The window's top-left corner is the programmed position minus the programmed hot-spot offset. The height is 16, 32, 64 or 128 lines. Corners that fall above or left of the screen origin are clipped.

At the start of each scan line the host pulses `line_start`. If that line lies inside the window and the pointer is on, the block raises a one-cycle fetch request that carries the row number. The memory side answers with `fetch_valid` and one 32-bit word for each plane. Each pixel of the image is a 2-bit code built from the two planes:

- background colour
- foreground colour
- screen pass-through
- inverted screen

An 8-bit mask limits which pixel bits the pointer may change. An optional blink counter, stepped by rising vertical sync edges, hides the pointer for half of each period.

Top module: `cursor_overlay`

## Requirements
- R1: While `cur_en` is low, `out_pix` equals the `scr_pix` sampled one clock earlier and `fetch_req` stays low.
- R2: `cur_height` selects the window height: 0 gives 16 lines, 1 gives 32, 2 gives 64 and 3 gives 128. Lines at or beyond that count below the top are left unchanged.
- R3: The window's left column is `pos_x - hot_x` and its top row is `pos_y - hot_y`. The window is 32 pixels wide, and pixels outside it pass `scr_pix` unchanged.
- R4: A negative left column or top row after the hot-spot subtraction clips the window. Only the part at coordinates 0 and above is drawn, using the row and column numbers measured from the true corner.
- R5: For a pixel inside the window, the code is {plane A bit, plane B bit}. Code 00 gives `bg_color`, 01 gives `fg_color`, 10 gives the screen pixel, and 11 gives the bitwise inverse of the screen pixel.
- R6: Window column c (0 = leftmost) uses bit 31-c of each plane word, so the leftmost eight pixels come from bits 31:24.
- R7: Only pixel bits set in `pix_mask` may differ from `scr_pix`. The result is (scr & ~mask) | (cursor & mask).
- R8: With `blink_en` high, the pointer is shown while the count of rising `vsync` edges (modulo 32) has bit 3 clear when `blink_slow` is low (8 shown, 8 hidden), or bit 4 clear when `blink_slow` is high (16 shown, 16 hidden). While `blink_en` is low the pointer is always shown and the count is held at zero.
- R9: One clock after `line_start` is sampled with `cur_en` high and `beam_y` inside the window, `fetch_req` is high for one cycle and `fetch_row` gives the row within the window. Plane words arriving with `fetch_valid` for that row are used for the rest of the line. No pointer pixels are drawn on a line whose words have not arrived.
- R10: `out_pix` is registered: the value for the inputs sampled at one rising edge appears right after that edge. After reset, `out_pix` and `fetch_req` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_en | input | 1 | Pointer enable |
| cur_height | input | 2 | Height select (16/32/64/128 lines) |
| blink_en | input | 1 | Blink enable |
| blink_slow | input | 1 | 1: 16/16 frames, 0: 8/8 frames |
| pos_x | input | 11 | Pointer horizontal position |
| pos_y | input | 10 | Pointer vertical position |
| hot_x | input | 6 | Hot-spot column offset |
| hot_y | input | 5 | Hot-spot row offset |
| fg_color | input | 8 | Foreground colour |
| bg_color | input | 8 | Background colour |
| pix_mask | input | 8 | Bits the pointer may modify |
| vsync | input | 1 | Vertical sync; rising edge steps blink |
| line_start | input | 1 | Start-of-line strobe |
| beam_x | input | 11 | Current beam column |
| beam_y | input | 10 | Current beam line |
| scr_pix | input | 8 | Underlying screen pixel |
| fetch_req | output | 1 | Request plane words for a row |
| fetch_row | output | 7 | Row within the window being requested |
| fetch_valid | input | 1 | Plane words present |
| plane_a | input | 32 | Plane A word for the requested row |
| plane_b | input | 32 | Plane B word for the requested row |
| out_pix | output | 8 | Final pixel |

## Verification
The pixel result is due one clock after its inputs are sampled. `fetch_req` is due one clock after `line_start`, and the plane words supplied with `fetch_valid` take effect from the following edge. The bench therefore drives every input on the falling edge and checks each output on the next falling edge. It first sends the line strobe and answers the fetch, and only then sweeps the columns. A vsync pulse changes the blink count at the first rising edge that sees it high. The bench counts these pulses itself and draws a test line after each one, so the shown/hidden phase is checked against the arithmetic count in every window.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int XW = 11,
  parameter int YW = 10,
  parameter int PW = 8,
  parameter int HXW = 6,
  parameter int HYW = 5,
  parameter int CW = 32,
  parameter int MINLOG = 4,
  parameter int BW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cur_en,
  input  logic [1:0]      cur_height,
  input  logic            blink_en,
  input  logic            blink_slow,
  input  logic [XW-1:0]   pos_x,
  input  logic [YW-1:0]   pos_y,
  input  logic [HXW-1:0]  hot_x,
  input  logic [HYW-1:0]  hot_y,
  input  logic [PW-1:0]   fg_color,
  input  logic [PW-1:0]   bg_color,
  input  logic [PW-1:0]   pix_mask,
  input  logic            vsync,
  input  logic            line_start,
  input  logic [XW-1:0]   beam_x,
  input  logic [YW-1:0]   beam_y,
  input  logic [PW-1:0]   scr_pix,
  output logic            fetch_req,
  output logic [MINLOG+2:0] fetch_row,
  input  logic            fetch_valid,
  input  logic [CW-1:0]   plane_a,
  input  logic [CW-1:0]   plane_b,
  output logic [PW-1:0]   out_pix
);
  localparam int XS = XW + 2;
  localparam int YS = YW + 2;
  localparam int CB = $clog2(CW);
  localparam int RW = MINLOG + 3;

  logic [XS-1:0] left_x, dx;
  logic [YS-1:0] top_y, dy, lines;
  logic          in_x, in_y, line_ok, blink_on, show;
  logic [CB-1:0] col, bsel;
  logic [1:0]    code;
  logic [PW-1:0] cur_pix, mixed;

  logic [CW-1:0] pa_q, pb_q;
  logic [RW-1:0] line_row;
  logic          line_vld;
  logic          vs_q;
  logic [BW-1:0] blink_cnt;

  assign left_x = {2'b00, pos_x} - XS'(hot_x);
  assign top_y  = {2'b00, pos_y} - YS'(hot_y);
  assign dx     = {2'b00, beam_x} - left_x;
  assign dy     = {2'b00, beam_y} - top_y;
  assign lines  = YS'(1) << (MINLOG + int'(cur_height));

  assign in_x = !dx[XS-1] && (dx < XS'(CW));
  assign in_y = !dy[YS-1] && (dy < lines);

  assign col  = dx[CB-1:0];
  assign bsel = CB'(CW - 1) - col;
  assign code = {pa_q[bsel], pb_q[bsel]};

  always_comb begin
    case (code)
      2'b00:   cur_pix = bg_color;
      2'b01:   cur_pix = fg_color;
      2'b10:   cur_pix = scr_pix;
      default: cur_pix = ~scr_pix;
    endcase
  end

  assign mixed    = (scr_pix & ~pix_mask) | (cur_pix & pix_mask);
  assign line_ok  = line_vld && (line_row == dy[RW-1:0]);
  assign blink_on = !blink_en || !(blink_slow ? blink_cnt[BW-1] : blink_cnt[BW-2]);
  assign show     = cur_en && in_x && in_y && line_ok && blink_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_req <= 1'b0;
      fetch_row <= '0;
      line_vld  <= 1'b0;
      line_row  <= '0;
      pa_q      <= '0;
      pb_q      <= '0;
    end else begin
      fetch_req <= 1'b0;
      if (line_start) begin
        line_vld <= 1'b0;
        if (cur_en && in_y) begin
          fetch_req <= 1'b1;
          fetch_row <= dy[RW-1:0];
        end
      end else if (fetch_valid) begin
        pa_q     <= plane_a;
        pb_q     <= plane_b;
        line_row <= fetch_row;
        line_vld <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_q      <= 1'b0;
      blink_cnt <= '0;
    end else begin
      vs_q <= vsync;
      if (!blink_en)
        blink_cnt <= '0;
      else if (vsync && !vs_q)
        blink_cnt <= blink_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_pix <= '0;
    else        out_pix <= show ? mixed : scr_pix;
  end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int PW = 8,
  parameter int MINLOG = 4,
  parameter int BW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cur_en,
  input logic [1:0]        cur_height,
  input logic              blink_en,
  input logic              line_start,
  input logic [PW-1:0]     scr_pix,
  input logic [PW-1:0]     pix_mask,
  input logic              fetch_req,
  input logic [MINLOG+2:0] fetch_row,
  input logic [PW-1:0]     out_pix,
  input logic [BW-1:0]     blink_cnt
);
  localparam int RW = MINLOG + 3;

  p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_en |=> (out_pix == $past(scr_pix)) && !fetch_req);

  p_mask_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((out_pix ^ $past(scr_pix)) & ~$past(pix_mask)) == '0);

  p_req_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_req) |-> $past(line_start) && $past(cur_en));

  p_row_height_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> ({1'b0, fetch_row} < ((RW+1)'(1) << (MINLOG + int'($past(cur_height))))));

  p_blink_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !blink_en |=> blink_cnt == '0);
endmodule

bind cursor_overlay cursor_overlay_chk #(.PW(PW), .MINLOG(MINLOG), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_en(cur_en), .cur_height(cur_height),
  .blink_en(blink_en), .line_start(line_start), .scr_pix(scr_pix),
  .pix_mask(pix_mask), .fetch_req(fetch_req), .fetch_row(fetch_row),
  .out_pix(out_pix), .blink_cnt(blink_cnt)
);

// File: tb/cursor_overlay_test.sv
`timescale 1ns/1ps
module cursor_overlay_test;
  logic clk = 0, rst_n = 0;
  logic cur_en = 0, blink_en = 0, blink_slow = 0, vsync = 0, line_start = 0, fetch_valid = 0;
  logic [1:0] cur_height = 0;
  logic [10:0] pos_x = 0, beam_x = 0;
  logic [9:0] pos_y = 0, beam_y = 0;
  logic [5:0] hot_x = 0;
  logic [4:0] hot_y = 0;
  logic [7:0] fg_color = 8'hE1, bg_color = 8'h1E, pix_mask = 8'hFF, scr_pix = 0;
  logic [31:0] plane_a = 0, plane_b = 0;
  logic fetch_req;
  logic [6:0] fetch_row;
  logic [7:0] out_pix;

  int checks = 0, failures = 0, nvs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cursor_overlay uut (
    .clk(clk), .rst_n(rst_n), .cur_en(cur_en), .cur_height(cur_height),
    .blink_en(blink_en), .blink_slow(blink_slow), .pos_x(pos_x), .pos_y(pos_y),
    .hot_x(hot_x), .hot_y(hot_y), .fg_color(fg_color), .bg_color(bg_color),
    .pix_mask(pix_mask), .vsync(vsync), .line_start(line_start),
    .beam_x(beam_x), .beam_y(beam_y), .scr_pix(scr_pix),
    .fetch_req(fetch_req), .fetch_row(fetch_row), .fetch_valid(fetch_valid),
    .plane_a(plane_a), .plane_b(plane_b), .out_pix(out_pix));

  function automatic logic [31:0] pat_a(int r);
    return (32'(r) * 32'h0101_0101) ^ 32'hF0CC_AA55;
  endfunction
  function automatic logic [31:0] pat_b(int r);
    return (32'(r) * 32'h0203_0405) ^ 32'h0FF0_33CC;
  endfunction
  function automatic logic [7:0] scr_of(int x, int y);
    return 8'(x * 3 + y * 7);
  endfunction

  function automatic bit row_in(int y);
    int r = y - (int'(pos_y) - int'(hot_y));
    return cur_en && r >= 0 && r < (16 << cur_height);
  endfunction

  function automatic logic [7:0] model(int x, int y);
    int c = x - (int'(pos_x) - int'(hot_x));
    int r = y - (int'(pos_y) - int'(hot_y));
    logic [7:0] s = scr_of(x, y);
    logic [7:0] cv;
    logic [31:0] a = pat_a(r), b = pat_b(r);
    bit vis = !blink_en || (((blink_slow ? (nvs % 32) >> 4 : (nvs % 32) >> 3) & 1) == 0);
    if (!cur_en || c < 0 || c > 31 || r < 0 || r >= (16 << cur_height) || !vis) return s;
    case ({a[31-c], b[31-c]})
      2'b00: cv = bg_color;
      2'b01: cv = fg_color;
      2'b10: cv = s;
      default: cv = ~s;
    endcase
    return (s & ~pix_mask) | (cv & pix_mask);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic draw_line(int y, int x0, int x1, string tag);
    bit er;
    @(negedge clk);
    line_start = 1; beam_y = 10'(y); beam_x = 11'd2047; scr_pix = scr_of(2047, y);
    er = row_in(y);
    @(negedge clk);
    line_start = 0;
    check({"R9 fetch_req ", tag}, 32'(fetch_req), 32'(er));
    if (er) begin
      check({"R9 fetch_row ", tag}, 32'(fetch_row), 32'(y - (int'(pos_y) - int'(hot_y))));
      fetch_valid = 1;
      plane_a = pat_a(int'(fetch_row));
      plane_b = pat_b(int'(fetch_row));
    end
    @(negedge clk);
    fetch_valid = 0;
    for (int x = x0; x <= x1; x++) begin
      beam_x = 11'(x); scr_pix = scr_of(x, y);
      @(negedge clk);
      check(tag, 32'(out_pix), 32'(model(x, y)));
    end
  endtask

  task automatic vs_pulse();
    @(negedge clk); vsync = 1;
    @(negedge clk); vsync = 0;
    nvs++;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset out_pix", 32'(out_pix), 0);
    check("R10 reset fetch_req", 32'(fetch_req), 0);
    rst_n = 1;

    pos_x = 100; hot_x = 5; pos_y = 50; hot_y = 3;
    draw_line(50, 90, 135, "R1 disabled");

    cur_en = 1;
    for (int y = 44; y <= 66; y++) draw_line(y, 90, 130, "R3 R5 R6 window");

    pix_mask = 8'h0F;
    for (int y = 47; y <= 52; y++) draw_line(y, 93, 129, "R7 mask");
    pix_mask = 8'hA0;
    draw_line(55, 93, 129, "R7 mask");
    pix_mask = 8'hFF;

    for (int h = 0; h < 4; h++) begin
      cur_height = 2'(h);
      draw_line(47 + (16 << h) - 1, 93, 129, "R2 last row");
      draw_line(47 + (16 << h), 93, 129, "R2 past end");
    end
    cur_height = 0;

    pos_x = 2; hot_x = 10; pos_y = 1; hot_y = 4;
    for (int y = 0; y <= 14; y++) draw_line(y, 0, 30, "R4 clipped");

    pos_x = 300; hot_x = 0; pos_y = 200; hot_y = 0;
    blink_en = 1; blink_slow = 0;
    @(negedge clk);
    nvs = 0;
    draw_line(203, 298, 312, "R8 fast");
    for (int i = 0; i < 40; i++) begin
      vs_pulse();
      draw_line(203, 298, 312, "R8 fast");
    end
    blink_slow = 1;
    for (int i = 0; i < 40; i++) begin
      vs_pulse();
      draw_line(205, 298, 312, "R8 slow");
    end
    blink_en = 0;
    @(negedge clk);
    nvs = 0;
    draw_line(206, 298, 312, "R8 off");
    blink_en = 1; blink_slow = 0;
    for (int i = 0; i < 10; i++) begin
      vs_pulse();
      draw_line(207, 298, 312, "R8 restart");
    end

    cur_en = 0;
    draw_line(207, 298, 312, "R1 disabled again");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule